// File: doc/BRIEF.md
# Serial Command Decoder for a Word Transmitter

This block is the host-side command front end of a serial word transmitter. A host talks to it over a four-wire serial link in mode 0 (clock idles low, data sampled on the rising clock edge, changed on the falling edge) with an active-low select. Every transaction opens with an 8-bit command byte, most significant bit first. The byte decides what follows. It can be a short register write, a register read shifted back on the serial output, an open-ended run of 32-bit words for the transmit queue, or nothing at all when the byte is a one-shot action.

The block owns a 16-bit control register and an 8-bit clock-divider register. It reads three flags from the transmit queue (empty, half full, full) and assembles them into an 8-bit status byte. Each completed 32-bit word becomes a one-cycle push strobe with its data. Queue clear, master reset and transmit start are one-cycle strobes that the queue and the transmitter act on. The serial pins are oversampled by the block's system clock through a synchroniser chain. The serial clock therefore has to be several system clocks per half period.

Top module: `spi_cmd_dec`

## Requirements
- R1: After reset the control and divider registers are 0, the serial output enable is low and no strobe is active. While select is low, the first 8 rising serial-clock edges shift in the command byte, most significant bit first.
- R2: Command 0x07 takes the next 8 bits, MSB first, as the divider value. Command 0x0C returns the divider value on the serial output, 8 bits, MSB first.
- R3: Command 0x10 takes the next 16 bits, MSB first, as the control register. Command 0x0B returns the control register, 16 bits, MSB first.
- R4: Command 0x0A returns an 8-bit status byte. Bit 3 is queue empty, bit 4 is half full and bit 5 is full. Bits 0-2, 6 and 7 read 0.
- R5: For a read command, the MSB of the value is on the serial output after the falling edge that follows the 8th command bit. Each later falling edge presents the next bit. The output enable stays high until select rises.
- R6: The serial output enable is low while select is high and for the whole of any command that is not a read.
- R7: Command 0x0E accepts any number of consecutive 32-bit words. Each completed word (MSB first) raises the push strobe once with that word. A word cut short by select rising is dropped.
- R8: A completed word is not pushed while the queue-full input is high.
- R9: Command 0x01 pulses master reset and queue clear after the 8th command bit while select is still low. The control and divider registers keep their values.
- R10: Command 0x11 pulses queue clear alone. Command 0x12 pulses transmit start alone. Both fire after the 8th command bit while select is low.
- R11: Every other command byte is a no-op, and its remaining bits are ignored until select rises. Bits after the data of a register write are ignored.
- R12: Every strobe (push, queue clear, master reset, transmit start) is high for exactly one system clock per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the serial data-out pad |
| q_empty | input | 1 | Transmit queue is empty |
| q_half | input | 1 | Transmit queue holds at least half its capacity |
| q_full | input | 1 | Transmit queue is full |
| ctrl_reg | output | 16 | Control register contents |
| div_reg | output | 8 | Divider register contents |
| push | output | 1 | One-cycle strobe: push push_data into the queue |
| push_data | output | 32 | Word to push |
| q_clear | output | 1 | One-cycle strobe: empty the queue |
| mreset | output | 1 | One-cycle master-reset strobe |
| tx_go | output | 1 | One-cycle transmit-start strobe |

## Verification
Assertions check on every cycle that the output enable drops once select goes high and is only ever high during a read. They also check that strobes last one cycle, that queue clear, push and transmit start never coincide, that master reset always carries a queue clear and leaves the control register untouched, and that no push follows a cycle with the queue full. Only the bench scenarios can show the bit order of writes and read-backs, the exact status bit positions, word framing over multi-word and truncated bursts, and that each of the undefined command bytes changes nothing.

// File: rtl/spi_cmd_pkg.sv
// Shared types and command codes for the serial command decoder.
// Assumes 8-bit command bytes; the code values are fixed by the host protocol.
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        ST_OPC  = 2'd0,   // collecting the command byte
        ST_WR   = 2'd1,   // collecting write data
        ST_RD   = 2'd2,   // serialising a read value
        ST_SKIP = 2'd3    // ignoring bits until select rises
    } dec_state_t;

    typedef enum logic [1:0] {
        TGT_DIV  = 2'd0,
        TGT_CTRL = 2'd1,
        TGT_WORD = 2'd2
    } wr_target_t;

    localparam logic [7:0] CMD_MRST     = 8'h01;
    localparam logic [7:0] CMD_DIV_WR   = 8'h07;
    localparam logic [7:0] CMD_STAT_RD  = 8'h0A;
    localparam logic [7:0] CMD_CTRL_RD  = 8'h0B;
    localparam logic [7:0] CMD_DIV_RD   = 8'h0C;
    localparam logic [7:0] CMD_WORD_WR  = 8'h0E;
    localparam logic [7:0] CMD_CTRL_WR  = 8'h10;
    localparam logic [7:0] CMD_Q_CLEAR  = 8'h11;
    localparam logic [7:0] CMD_TX_GO    = 8'h12;

endpackage

// File: rtl/spi_pin_sync.sv
// Synchronises the three serial input pins into the system clock domain
// and detects serial-clock edges. Assumes each serial-clock half period
// lasts longer than STAGES+1 system clocks. Select is inverted to active high.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sel,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    logic [STAGES-1:0][2:0] chain;
    logic                   sck_prev;

    // Shift {select, clock, data} through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain    <= '0;
            sck_prev <= 1'b0;
        end else begin
            chain[0] <= {~cs_n, sck, si};
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            sck_prev <= chain[STAGES-1][1];
        end
    end

    assign sel      = chain[STAGES-1][2];
    assign si_s     = chain[STAGES-1][0];
    assign sck_rise = chain[STAGES-1][1] & ~sck_prev;
    assign sck_fall = ~chain[STAGES-1][1] & sck_prev;
endmodule

// File: rtl/spi_cmd_regs.sv
// Holds the control and divider registers. Each write enable loads its
// register for one cycle. A master reset does not reach this module.
module spi_cmd_regs #(
    parameter int CTRL_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DIV_W-1:0]  div_q
);
    // Load the control register on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Load the divider register on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_we) div_q <= div_wdata;
    end
endmodule

// File: rtl/spi_so_shifter.sv
// Serialises a read value onto the data-out pin. The value is loaded
// MSB-aligned when a read command completes. Each later serial-clock fall
// presents the next bit and raises the enable. Select going away idles it.
module spi_so_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              sck_fall,
    output logic              so,
    output logic              so_oe
);
    logic [WORD_W-1:0] sh;
    logic              armed;

    // Load, then shift out one bit per falling serial-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            sh    <= '0;
            armed <= 1'b0;
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else if (load) begin
            sh    <= load_val;
            armed <= 1'b1;
        end else if (sck_fall && armed) begin
            so    <= sh[WORD_W-1];
            sh    <= {sh[WORD_W-2:0], 1'b0};
            so_oe <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_cmd_dec.sv
// Serial command decoder (mode 0, active-low select). Collects the command
// byte, then routes data to the registers or the word queue, serialises
// read-backs, or fires one-shot strobes. Assumes the queue flags are
// synchronous to clk and the serial clock is slow relative to clk.
module spi_cmd_dec #(
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_W      = 16,
    parameter int DIV_W       = 8,
    parameter int WORD_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              q_empty,
    input  logic              q_half,
    input  logic              q_full,
    output logic [CTRL_W-1:0] ctrl_reg,
    output logic [DIV_W-1:0]  div_reg,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              q_clear,
    output logic              mreset,
    output logic              tx_go
);
    import spi_cmd_pkg::*;

    localparam int OP_W  = 8;
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] OP_LAST = CNT_W'(OP_W - 1);

    logic              sel, sck_rise, sck_fall, si_s;
    dec_state_t        st;
    wr_target_t        tgt;
    logic [CNT_W-1:0]  bcnt, wlast;
    logic [OP_W-2:0]   op_sh;
    logic [WORD_W-2:0] in_sh;
    logic [OP_W-1:0]   op_nxt;
    logic [WORD_W-1:0] word_nxt, rd_val;
    logic              op_done, commit, rd_load;
    logic [7:0]        status;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
    );

    assign op_nxt   = {op_sh, si_s};
    assign word_nxt = {in_sh, si_s};
    assign op_done  = sel && sck_rise && (st == ST_OPC) && (bcnt == OP_LAST);
    assign commit   = sel && sck_rise && (st == ST_WR) && (bcnt == wlast);
    assign status   = {2'b00, q_full, q_half, q_empty, 3'b000};

    // Pick the MSB-aligned read-back value for a completing read command.
    always_comb begin
        rd_load = op_done;
        case (op_nxt)
            CMD_STAT_RD: rd_val = {status, {(WORD_W-8){1'b0}}};
            CMD_CTRL_RD: rd_val = {ctrl_reg, {(WORD_W-CTRL_W){1'b0}}};
            CMD_DIV_RD:  rd_val = {div_reg, {(WORD_W-DIV_W){1'b0}}};
            default: begin
                rd_val  = '0;
                rd_load = 1'b0;
            end
        endcase
    end

    spi_cmd_regs #(.CTRL_W(CTRL_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(commit && (tgt == TGT_CTRL)), .ctrl_wdata(word_nxt[CTRL_W-1:0]),
        .div_we(commit && (tgt == TGT_DIV)), .div_wdata(word_nxt[DIV_W-1:0]),
        .ctrl_q(ctrl_reg), .div_q(div_reg)
    );

    spi_so_shifter #(.WORD_W(WORD_W)) u_so (
        .clk(clk), .rst_n(rst_n), .sel(sel), .load(rd_load), .load_val(rd_val),
        .sck_fall(sck_fall), .so(so), .so_oe(so_oe)
    );

    // Command/data sequencer and one-cycle strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_OPC;  tgt <= TGT_DIV;  bcnt <= '0;  wlast <= '0;
            op_sh <= '0;   in_sh <= '0;
            push <= 1'b0;  push_data <= '0;
            q_clear <= 1'b0;  mreset <= 1'b0;  tx_go <= 1'b0;
        end else begin
            push <= 1'b0;  q_clear <= 1'b0;  mreset <= 1'b0;  tx_go <= 1'b0;
            if (!sel) begin
                st   <= ST_OPC;
                bcnt <= '0;
            end else if (sck_rise) begin
                case (st)
                    ST_OPC: begin
                        op_sh <= op_nxt[OP_W-2:0];
                        if (bcnt == OP_LAST) begin
                            bcnt <= '0;
                            st   <= ST_SKIP;
                            case (op_nxt)
                                CMD_MRST:    begin mreset <= 1'b1; q_clear <= 1'b1; end
                                CMD_Q_CLEAR: q_clear <= 1'b1;
                                CMD_TX_GO:   tx_go   <= 1'b1;
                                CMD_DIV_WR:  begin st <= ST_WR; tgt <= TGT_DIV;  wlast <= CNT_W'(DIV_W-1);  end
                                CMD_CTRL_WR: begin st <= ST_WR; tgt <= TGT_CTRL; wlast <= CNT_W'(CTRL_W-1); end
                                CMD_WORD_WR: begin st <= ST_WR; tgt <= TGT_WORD; wlast <= CNT_W'(WORD_W-1); end
                                CMD_STAT_RD, CMD_CTRL_RD, CMD_DIV_RD: st <= ST_RD;
                                default: ;
                            endcase
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    ST_WR: begin
                        in_sh <= word_nxt[WORD_W-2:0];
                        if (commit) begin
                            bcnt <= '0;
                            if (tgt == TGT_WORD) begin
                                push      <= !q_full;
                                push_data <= word_nxt;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6
    so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !so_oe);

    // R5
    so_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (st == ST_RD));

    // R9
    mreset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |-> q_clear);

    // R9
    mreset_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> $stable(ctrl_reg));

    // R8
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !$past(q_full));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, q_clear, tx_go}));

    // R12
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push || q_clear || mreset || tx_go) |=> !(push || q_clear || mreset || tx_go));
endmodule

// File: tb/spi_cmd_dec_bench.sv
module spi_cmd_dec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;    // system clocks per serial half period

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic q_empty = 1'b1, q_half = 1'b0, q_full = 1'b0;
    logic so, so_oe, push, q_clear, mreset, tx_go;
    logic [15:0] ctrl_reg;
    logic [7:0]  div_reg;
    logic [31:0] push_data;

    int errors = 0, checks = 0;
    int n_push = 0, n_clr = 0, n_mr = 0, n_go = 0;
    bit strobe_sel_ok = 1'b1, oe_seen = 1'b0, done = 1'b0;
    logic [31:0]  words [0:15];
    logic [127:0] rd_bits;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_dec u_spi_cmd_dec (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .q_empty(q_empty), .q_half(q_half), .q_full(q_full),
        .ctrl_reg(ctrl_reg), .div_reg(div_reg), .push(push), .push_data(push_data),
        .q_clear(q_clear), .mreset(mreset), .tx_go(tx_go)
    );

    // Count strobes away from the active edge and note select state.
    always @(negedge clk) begin
        if (rst_n) begin
            if (push) begin
                if (n_push < 16) words[n_push] = push_data;
                n_push++;
            end
            if (q_clear) n_clr++;
            if (mreset)  n_mr++;
            if (tx_go)   n_go++;
            if ((q_clear || mreset || tx_go) && cs_n) strobe_sel_ok = 1'b0;
            if (so_oe) oe_seen = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One transaction: command byte, then nd data bits (right-aligned in d).
    // SO is sampled before every rising edge after the command byte.
    task automatic frame(input logic [7:0] op, input int nd, input logic [127:0] d);
        rd_bits = '0;
        oe_seen = 1'b0;
        cs_n = 1'b0;
        for (int i = 0; i < 8 + nd; i++) begin
            si = (i < 8) ? op[7-i] : d[nd-1-(i-8)];
            wait_clk(HALF);
            if (i >= 8) rd_bits = {rd_bits[126:0], so};
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        si = 1'b0;
        wait_clk(2 * HALF);
    endtask

    function automatic bit is_defined(input logic [7:0] op);
        return op == 8'h01 || op == 8'h07 || op == 8'h0A || op == 8'h0B || op == 8'h0C ||
               op == 8'h0E || op == 8'h10 || op == 8'h11 || op == 8'h12;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] cv;
        logic [7:0]  dv;
        logic [7:0]  sv;
        int np, nc, nm, ng;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: reset state
        chk(ctrl_reg == 0, "R1 ctrl reset", ctrl_reg, 0);
        chk(div_reg == 0, "R1 div reset", div_reg, 0);
        chk(!so_oe, "R1 oe reset", so_oe, 0);
        chk(n_push + n_clr + n_mr + n_go == 0, "R1 no strobes", n_push + n_clr + n_mr + n_go, 0);

        // R3/R1/R5: control write and read-back sweep (walking ones plus patterns)
        for (int k = 0; k < 20; k++) begin
            cv = (k < 16) ? (16'h1 << k) : 16'(32'hA5C3 * k + 32'h1234);
            frame(8'h10, 16, {112'b0, cv});
            chk(ctrl_reg == cv, "R3 ctrl write", ctrl_reg, cv);
            chk(!oe_seen, "R6 no oe on write", oe_seen, 0);
            frame(8'h0B, 16, '0);
            chk(rd_bits[15:0] == cv, "R5 R3 ctrl readback", rd_bits[15:0], cv);
            chk(oe_seen, "R5 oe during read", oe_seen, 1);
            chk(!so_oe, "R6 oe off after select", so_oe, 0);
        end

        // R2: divider write and read-back sweep
        for (int k = 0; k < 17; k++) begin
            dv = (k < 16) ? 8'(k * 17) : 8'h5A;
            frame(8'h07, 8, {120'b0, dv});
            chk(div_reg == dv, "R2 div write", div_reg, dv);
            frame(8'h0C, 8, '0);
            chk(rd_bits[7:0] == dv, "R2 div readback", rd_bits[7:0], dv);
        end

        // R4: all status flag combinations
        for (int k = 0; k < 8; k++) begin
            {q_full, q_half, q_empty} = 3'(k);
            sv = {2'b00, 3'(k), 3'b000};
            frame(8'h0A, 8, '0);
            chk(rd_bits[7:0] == sv, "R4 status", rd_bits[7:0], sv);
        end
        {q_full, q_half, q_empty} = 3'b001;

        // R7: three-word burst
        np = n_push;
        frame(8'h0E, 96, {32'b0, 32'hDEADBEEF, 32'h00000001, 32'h80000000});
        chk(n_push - np == 3, "R7 burst count", n_push - np, 3);
        chk(words[np] == 32'hDEADBEEF, "R7 word0", words[np], 32'hDEADBEEF);
        chk(words[np+1] == 32'h00000001, "R7 word1", words[np+1], 32'h1);
        chk(words[np+2] == 32'h80000000, "R7 word2", words[np+2], 32'h80000000);
        chk(!oe_seen, "R6 no oe on burst", oe_seen, 0);

        // R7: truncated second word is dropped
        np = n_push;
        frame(8'h0E, 40, {88'b0, 32'h13572468, 8'hFF});
        chk(n_push - np == 1, "R7 partial word dropped", n_push - np, 1);
        chk(words[np] == 32'h13572468, "R7 partial first word", words[np], 32'h13572468);

        // R8: queue full discards words
        q_full = 1'b1;
        np = n_push;
        frame(8'h0E, 64, {64'b0, 64'h0123456789ABCDEF});
        chk(n_push == np, "R8 no push when full", n_push - np, 0);
        q_full = 1'b0;

        // R9: master reset
        frame(8'h10, 16, {112'b0, 16'hBEEF});
        frame(8'h07, 8, {120'b0, 8'h3C});
        nc = n_clr; nm = n_mr; ng = n_go; np = n_push;
        strobe_sel_ok = 1'b1;
        frame(8'h01, 0, '0);
        chk(n_mr - nm == 1, "R9 R12 one mreset", n_mr - nm, 1);
        chk(n_clr - nc == 1, "R9 clear with mreset", n_clr - nc, 1);
        chk(strobe_sel_ok, "R9 fires while select low", strobe_sel_ok, 1);
        chk(ctrl_reg == 16'hBEEF, "R9 ctrl kept", ctrl_reg, 16'hBEEF);
        chk(div_reg == 8'h3C, "R9 div kept", div_reg, 8'h3C);

        // R10: queue clear and transmit start
        nc = n_clr; nm = n_mr; ng = n_go;
        frame(8'h11, 0, '0);
        chk(n_clr - nc == 1 && n_mr == nm && n_go == ng, "R10 R12 clear only", n_clr - nc, 1);
        nc = n_clr;
        frame(8'h12, 0, '0);
        chk(n_go - ng == 1 && n_clr == nc && n_mr == nm, "R10 R12 start only", n_go - ng, 1);
        chk(strobe_sel_ok, "R10 fires while select low", strobe_sel_ok, 1);

        // R11: extra bits after a control write are ignored
        frame(8'h10, 24, {104'b0, 16'h1357, 8'hFF});
        chk(ctrl_reg == 16'h1357, "R11 trailing bits ignored", ctrl_reg, 16'h1357);

        // R11: every undefined command byte is a no-op
        nc = n_clr; nm = n_mr; ng = n_go; np = n_push;
        for (int op = 0; op < 256; op++) begin
            if (!is_defined(8'(op))) begin
                frame(8'(op), 16, {112'b0, 16'hFFFF});
                if (ctrl_reg != 16'h1357 || div_reg != 8'h3C || oe_seen)
                    chk(1'b0, "R11 undefined opcode effect", {op[7:0], ctrl_reg, div_reg}, {op[7:0], 16'h1357, 8'h3C});
            end
        end
        chk(ctrl_reg == 16'h1357 && div_reg == 8'h3C, "R11 registers after sweep", ctrl_reg, 16'h1357);
        chk(n_clr == nc && n_mr == nm && n_go == ng && n_push == np, "R11 no strobes in sweep",
            n_clr + n_mr + n_go + n_push - nc - nm - ng - np, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule